// File: doc/BRIEF.md
# Task-Tagged Memory Controller with Error Log

This block sits between the microcode sequencer of a small processor and a word memory. The sequencer loads an address, which at once reads the addressed word into a latch together with a flag telling whether the address lies inside populated memory. It stores words through a data-write strobe, which targets the address currently held. It consumes the latched word through a data-read strobe that carries the number of the microcode task asking. The outcome of each such read is logged in a shared status word, with one error flag per task and a double-bit flag. A control write loads a six-bit diagnostic check field and can drop the error flag of one chosen task.

Memory beyond the populated size, set by a parameter, counts as nonexistent. It reads back as zero with the valid flag low, and writes to it are dropped. The status word, the latched word, its valid flag, the address register and the check field are all outputs that can be observed at any time.

Top module: `tagged_memctl`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_q`, `rd_data`, `status` and `check_bits` become 0 and `rd_valid` becomes 1.
- R2: `addr_load` at an edge loads `addr_in` into `addr_q` and sets `rd_valid` to 1 exactly when `addr_in` < MEM_WORDS. Without `addr_load`, `addr_q`, `rd_data` and `rd_valid` hold.
- R3: `data_wr` at an edge stores `data_in` at `addr_q`, and a later load of that address returns it on `rd_data`. When `addr_load` of the same address comes in the same cycle, `rd_data` gets the word as it was before that write.
- R4: A `data_wr` while `addr_q` >= MEM_WORDS changes no stored word, including the word at the address that shares its low bits.
- R5: A load of an address >= MEM_WORDS gives `rd_data` = 0 and `rd_valid` = 0.
- R6: `data_rd` with `rd_valid` = 0 sets `status[7 - rd_task]` and `status[8]` (the double-bit flag) at that edge.
- R7: `data_rd` with `rd_valid` = 1 clears `status[8]` and `status[9]` (the single-bit flag) and leaves the other bits as they were.
- R8: `ctl_wr` loads `ctl_in[7:2]` into `check_bits`.
- R9: `ctl_wr` with `ctl_in[11]` = 1 clears `status[7 - ctl_in[10:8]]`. With `ctl_in[11]` = 0 it leaves `status` unchanged.
- R10: When an R9 clear and an R6 set hit the same status bit in one cycle, the bit ends up set.
- R11: `status[15:9]` always reads 0, because no event in the block sets any of those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Load address and latch the word it reads |
| addr_in | input | ADDR_W | Address to load |
| data_wr | input | 1 | Store `data_in` at `addr_q` |
| data_in | input | DATA_W | Word to store |
| data_rd | input | 1 | Consume latched word and log its outcome |
| rd_task | input | 3 | Task number for `data_rd` |
| ctl_wr | input | 1 | Control write strobe |
| ctl_in | input | 16 | Control word: [7:2] check bits, [11] clear enable, [10:8] task |
| rd_data | output | DATA_W | Latched word |
| rd_valid | output | 1 | Latched valid flag |
| status | output | 16 | Error log: [7-t] task t, [8] double-bit, [9] single-bit |
| check_bits | output | 6 | Diagnostic check field |
| addr_q | output | ADDR_W | Current address register |

## Verification
Every result is due one rising edge after the stimulus that causes it. The address, latched word and valid flag follow a load at that edge, as do the status bits after a data read or control write and the check field after a control write. A stored word shows up only through a later load, so it appears one edge after that load. The bench drives all inputs at the falling edge, advances a reference model at the rising edge using the values from before the edge, and compares every output at the next falling edge. The data output is compared only once the model knows the word it latched.

// File: rtl/memctl_pkg.sv
`timescale 1ns/1ps
package memctl_pkg;
  localparam int ADDR_W_DEF   = 20;
  localparam int DATA_W_DEF   = 16;
  localparam int MEM_WORDS_DEF = 1024;
  localparam int TASK_W       = 3;
  localparam int NUM_TASKS    = 1 << TASK_W;
  localparam int STAT_W       = 16;
  localparam int CHK_W        = 6;
  localparam int DBL_BIT      = 8;
  localparam int SGL_BIT      = 9;
  localparam int CTL_CLR_BIT  = 11;
  localparam int CTL_TASK_LO  = 8;
  localparam int CTL_CHK_LO   = 2;

  // Status bit owned by a task: task 0 sits at the top of the low byte.
  function automatic int task_flag_pos(input int t);
    return NUM_TASKS - 1 - t;
  endfunction
endpackage

// File: rtl/memctl_ram.sv
`timescale 1ns/1ps
module memctl_ram #(
  parameter int DEPTH  = 1024,
  parameter int WIDTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             rd_en,
  input  logic             rd_zero,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Write port: plain array write so a block RAM is inferred.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  // Read port: the output register samples the array before this edge's
  // write lands, giving read-first behaviour on a shared address.
  always_ff @(posedge clk) begin
    if (rst)        rd_word <= '0;
    else if (rd_en) rd_word <= rd_zero ? '0 : mem[rd_idx];
  end
endmodule

// File: rtl/memctl_addr.sv
`timescale 1ns/1ps
module memctl_addr #(
  parameter int ADDR_W    = 20,
  parameter int MEM_WORDS = 1024,
  localparam int IDX_W    = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              valid_q,
  output logic              in_range_new,
  output logic              in_range_cur,
  output logic [IDX_W-1:0]  idx_new,
  output logic [IDX_W-1:0]  idx_cur
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_WORDS);

  assign in_range_new = {1'b0, addr_in} < LIMIT;
  assign in_range_cur = {1'b0, addr_q}  < LIMIT;
  assign idx_new      = addr_in[IDX_W-1:0];
  assign idx_cur      = addr_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b1;
    end else if (load) begin
      addr_q  <= addr_in;
      valid_q <= in_range_new;
    end
  end
endmodule

// File: rtl/memctl_status.sv
`timescale 1ns/1ps
module memctl_status
  import memctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [TASK_W-1:0] rd_task,
  input  logic              rd_ok,
  input  logic              ctl_wr,
  input  logic [STAT_W-1:0] ctl_word,
  output logic [STAT_W-1:0] status_q,
  output logic [CHK_W-1:0]  chk_q
);
  logic [NUM_TASKS-1:0] task_err;
  logic                 dbl_err;
  logic                 sgl_err;
  logic                 clr_req;
  logic [TASK_W-1:0]    clr_task;

  assign clr_req  = ctl_wr && ctl_word[CTL_CLR_BIT];
  assign clr_task = ctl_word[CTL_TASK_LO +: TASK_W];

  // One flag per task; a set from a failed read overrides a clear.
  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_task
    logic set_g, clr_g;
    assign set_g = rd_req && !rd_ok && (rd_task == TASK_W'(g));
    assign clr_g = clr_req && (clr_task == TASK_W'(g));
    always_ff @(posedge clk) begin
      if (rst)        task_err[g] <= 1'b0;
      else if (set_g) task_err[g] <= 1'b1;
      else if (clr_g) task_err[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbl_err <= 1'b0;
      sgl_err <= 1'b0;
    end else if (rd_req) begin
      dbl_err <= !rd_ok;
      if (rd_ok) sgl_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         chk_q <= '0;
    else if (ctl_wr) chk_q <= ctl_word[CTL_CHK_LO +: CHK_W];
  end

  always_comb begin
    status_q = '0;
    for (int t = 0; t < NUM_TASKS; t++) status_q[task_flag_pos(t)] = task_err[t];
    status_q[DBL_BIT] = dbl_err;
    status_q[SGL_BIT] = sgl_err;
  end
endmodule

// File: rtl/tagged_memctl.sv
`timescale 1ns/1ps
module tagged_memctl
  import memctl_pkg::*;
#(
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int DATA_W    = DATA_W_DEF,
  parameter int MEM_WORDS = MEM_WORDS_DEF,
  localparam int IDX_W    = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              data_rd,
  input  logic [TASK_W-1:0] rd_task,
  input  logic              ctl_wr,
  input  logic [STAT_W-1:0] ctl_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [STAT_W-1:0] status,
  output logic [CHK_W-1:0]  check_bits,
  output logic [ADDR_W-1:0] addr_q
);
  logic             in_range_new, in_range_cur;
  logic [IDX_W-1:0] idx_new, idx_cur;

  memctl_addr #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_addr (
    .clk(clk), .rst(rst), .load(addr_load), .addr_in(addr_in),
    .addr_q(addr_q), .valid_q(rd_valid),
    .in_range_new(in_range_new), .in_range_cur(in_range_cur),
    .idx_new(idx_new), .idx_cur(idx_cur)
  );

  memctl_ram #(.DEPTH(MEM_WORDS), .WIDTH(DATA_W)) u_ram (
    .clk(clk), .rst(rst),
    .wr_en(data_wr && in_range_cur), .wr_idx(idx_cur), .wr_word(data_in),
    .rd_en(addr_load), .rd_zero(!in_range_new), .rd_idx(idx_new),
    .rd_word(rd_data)
  );

  memctl_status u_status (
    .clk(clk), .rst(rst),
    .rd_req(data_rd), .rd_task(rd_task), .rd_ok(rd_valid),
    .ctl_wr(ctl_wr), .ctl_word(ctl_in),
    .status_q(status), .chk_q(check_bits)
  );
endmodule

// File: rtl/memctl_chk.sv
`timescale 1ns/1ps
module memctl_chk
  import memctl_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int MEM_WORDS = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_load,
  input logic [ADDR_W-1:0] addr_in,
  input logic              data_rd,
  input logic [TASK_W-1:0] rd_task,
  input logic              ctl_wr,
  input logic [STAT_W-1:0] ctl_in,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [STAT_W-1:0] status,
  input logic [CHK_W-1:0]  check_bits,
  input logic [ADDR_W-1:0] addr_q
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_WORDS);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == '0 && rd_valid && addr_q == '0 && check_bits == '0));
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    addr_load |=> (addr_q == $past(addr_in)) &&
                  (rd_valid == ({1'b0, $past(addr_in)} < LIMIT)));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_load |=> $stable(addr_q) && $stable(rd_valid) && $stable(rd_data));
  // R6
  bad_read_log_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !rd_valid) |=> status[DBL_BIT] && status[7 - $past(rd_task)]);
  // R7
  good_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && rd_valid) |=> status[SGL_BIT:DBL_BIT] == 2'b00);
  // R8
  check_field_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> check_bits == $past(ctl_in[CTL_CHK_LO +: CHK_W]));
  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status[STAT_W-1:SGL_BIT] == '0);
endmodule

bind tagged_memctl memctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_chk (
  .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
  .data_rd(data_rd), .rd_task(rd_task), .ctl_wr(ctl_wr), .ctl_in(ctl_in),
  .rd_data(rd_data), .rd_valid(rd_valid), .status(status),
  .check_bits(check_bits), .addr_q(addr_q)
);

// File: tb/tagged_memctl_bench.sv
`timescale 1ns/1ps
module tagged_memctl_bench;
  localparam int MW = 1024;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          addr_load = 0, data_wr = 0, data_rd = 0, ctl_wr = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [2:0]    rd_task = '0;
  logic [15:0]   ctl_in = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [15:0]   status;
  logic [5:0]    check_bits;
  logic [AW-1:0] addr_q;

  tagged_memctl #(.ADDR_W(AW), .DATA_W(DW), .MEM_WORDS(MW)) u_tagged_memctl (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .data_wr(data_wr), .data_in(data_in), .data_rd(data_rd), .rd_task(rd_task),
    .ctl_wr(ctl_wr), .ctl_in(ctl_in), .rd_data(rd_data), .rd_valid(rd_valid),
    .status(status), .check_bits(check_bits), .addr_q(addr_q)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [MW];
  bit            m_known [MW];
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  bit            m_valid = 1, m_dknown = 1;
  logic [15:0]   m_status = '0;
  logic [5:0]    m_chk = '0;

  function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  task automatic compare(string tag);
    chk(tag, "addr_q", 32'(addr_q), 32'(m_addr));
    chk(tag, "rd_valid", 32'(rd_valid), 32'(m_valid));
    if (m_dknown) chk(tag, "rd_data", 32'(rd_data), 32'(m_data));
    chk(tag, "status", 32'(status), 32'(m_status));
    chk(tag, "check_bits", 32'(check_bits), 32'(m_chk));
    chk("R11", "status upper", 32'(status[15:9]), 32'd0);
  endtask

  // Drive at a falling edge, model the rising edge, compare at the next falling edge.
  task automatic step(string tag, bit ld, logic [AW-1:0] a, bit wr, logic [DW-1:0] d,
                      bit rd, logic [2:0] t, bit cw, logic [15:0] c);
    logic [15:0] ns;
    addr_load = ld; addr_in = a; data_wr = wr; data_in = d;
    data_rd = rd; rd_task = t; ctl_wr = cw; ctl_in = c;
    @(posedge clk);
    ns = m_status;
    if (cw) begin
      m_chk = c[7:2];
      if (c[11]) ns[7 - int'(c[10:8])] = 1'b0;
    end
    if (rd) begin
      if (!m_valid) begin ns[7 - int'(t)] = 1'b1; ns[8] = 1'b1; end
      else ns[9:8] = 2'b00;
    end
    m_status = ns;
    if (ld) begin
      if (a < MW) begin m_data = m_mem[a]; m_dknown = m_known[a]; m_valid = 1; end
      else begin m_data = '0; m_dknown = 1; m_valid = 0; end
    end
    if (wr && m_addr < MW) begin m_mem[m_addr] = d; m_known[m_addr] = 1; end
    if (ld) m_addr = a;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < MW; i++) m_known[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    compare("R1");
    // R5: nonexistent address reads as zero, invalid
    step("R5", 1, AW'(MW), 0, 0, 0, 0, 0, 0);
    // R6: failed read logs task 2 and double-bit flag
    step("R6", 0, 0, 0, 0, 1, 3'd2, 0, 0);
    // R9: clear without enable does nothing, then clear task 2
    step("R9", 0, 0, 0, 0, 0, 0, 1, 16'h0200);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 16'h0A00);
    // R10: clear and set of task 4 in one cycle, set wins
    step("R10", 0, 0, 0, 0, 1, 3'd4, 1, 16'h0C00);
    // R3: store at address 0 and read it back
    step("R3", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 16'h1234, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 0, 0, 0, 0);
    // R4: write at alias of address 0 beyond populated range is dropped
    step("R4", 1, AW'(MW), 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 1, 16'hBEEF, 0, 0, 0, 0);
    step("R4", 1, 0, 0, 0, 0, 0, 0, 0);
    // R3: load and write of the same address in one cycle latch the old word
    step("R3", 1, 0, 1, 16'h5555, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 0, 0, 0, 0);
    // R7: good read clears bits 9:8, keeps task 4 flag
    step("R7", 0, 0, 0, 0, 1, 3'd1, 0, 0);
    // R8: check field load
    step("R8", 0, 0, 0, 0, 0, 0, 1, 16'h00FC);
    // R2: top of populated range and first address past it
    step("R2", 1, AW'(MW - 1), 0, 0, 0, 0, 0, 0);
    step("R2", 1, AW'(MW), 0, 0, 0, 0, 0, 0);
    // R2: random mix of all operations
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      int r;
      r = int'($urandom % 8);
      if (r == 0)      a = AW'($urandom);
      else if (r == 1) a = AW'(MW - 1 + int'($urandom % 3));
      else             a = AW'($urandom % 64);
      step("R2", ($urandom % 10) < 4, a, ($urandom % 10) < 4, DW'($urandom),
           ($urandom % 10) < 4, 3'($urandom), ($urandom % 20) < 3, 16'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule